// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block takes an SDRAM from power-up to normal operation by issuing commands to a downstream SDRAM command generator. Once `start` is sampled while the block is idle, it issues a fixed series of one-cycle command strobes, each with a 3-bit opcode:

1. A precharge-all command.
2. Eight auto-refresh commands.
3. A mode-register write that carries a programmable mode word.
4. A final normal-operation command.

A programmable quiet gap follows each command before the next one: T_RP cycles after the precharge, T_RFC cycles after each refresh and T_MRD cycles after the mode write.

When the normal-operation command goes out, the block raises `init_done` and arms a refresh-interval timer. The timer is built from a 16-bit prescaler and an 8-bit refresh counter. While it is armed, it pulses `refresh_req` once every (prescaler+1)·(timer+1) clock cycles. Pulsing `refresh_clear` disarms the timer, which then stops and reloads. A synchronous reset returns everything to idle with refresh disarmed.

The control is a state machine with these states:

- `ST_IDLE` moves to `ST_PRECH` on `start`.
- `ST_PRECH` moves to `ST_PRE_GAP`.
- `ST_PRE_GAP` moves to `ST_REFR` when its gap expires.
- `ST_REFR` moves to `ST_REF_GAP`.
- `ST_REF_GAP` returns to `ST_REFR` when its gap expires and fewer than eight refreshes have gone out. After the eighth refresh it moves on to `ST_MRW` instead.
- `ST_MRW` moves to `ST_MRW_GAP`.
- `ST_MRW_GAP` moves to `ST_NORM` when its gap expires.
- `ST_NORM` moves to `ST_RUN`.
- `ST_RUN` is terminal until reset.

Top module: `sdram_bringup`

## Requirements
- R1: After a synchronous reset, the outputs are all low: `cmd_valid`, `cmd_op`, `cmd_mode`, `init_done`, `refresh_en` and `refresh_req`. A reset during the sequence abandons it, and no further strobe is issued until a new `start`.
- R2: The cycle after `start` is sampled in idle carries a strobe with opcode 3'b101 (precharge all).
- R3: After the precharge strobe and T_RP quiet cycles, the block issues exactly eight strobes with opcode 3'b001 (auto refresh). Each of them is followed by T_RFC quiet cycles.
- R4: Following the last refresh gap, one strobe with opcode 3'b011 (mode register write) is issued. In that cycle `cmd_mode` equals `mode_word`; in every other cycle `cmd_mode` is zero.
- R5: T_MRD quiet cycles after the mode write, a strobe with opcode 3'b000 (normal operation) is issued. `init_done` rises in that cycle and stays high until reset. `refresh_en` rises in the following cycle.
- R6: Every strobe lasts exactly one cycle, and `cmd_op` reads 0 whenever `cmd_valid` is low.
- R7: `refresh_req` stays low while `refresh_en` is low. With P = `ref_presc` and T = `ref_timer`, the first one-cycle pulse comes (P+1)(T+1) cycles after `refresh_en` rises, and further pulses follow at that same period.
- R8: A pulse on `refresh_clear` drops `refresh_en` at the next edge. The interval timer then stops and reloads, and no further `refresh_req` pulse appears.
- R9: `start` has no effect once a sequence has begun, whether the sequence is still running or already finished.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Launch the bring-up sequence (accepted in idle only) |
| mode_word | input | MODE_W | Value carried by the mode-register write |
| ref_presc | input | PRE_W | Refresh prescaler setting |
| ref_timer | input | RT_W | Refresh counter setting |
| refresh_clear | input | 1 | Disarm periodic refresh |
| cmd_valid | output | 1 | One-cycle command strobe |
| cmd_op | output | 3 | Command opcode (0 when no strobe) |
| cmd_mode | output | MODE_W | Mode value, nonzero only with a mode-write strobe |
| init_done | output | 1 | Normal operation entered |
| refresh_en | output | 1 | Periodic refresh armed |
| refresh_req | output | 1 | One-cycle periodic refresh request |

## Verification
The bench builds the block with T_RP=2, T_RFC=3 and T_MRD=1. The 1-cycle mode-write gap tests the shortest legal wait, and the eight-refresh loop stays short enough to cover several full sequences. The refresh settings are varied across runs:

- P=2, T=3 gives a period of 12.
- P=0, T=0 gives a period of 1, so the request stays high every cycle.
- P=4, T=0 exercises a prescaler-only interval.

Reset in the middle of the sequence and `start` pulses during and after the sequence are also applied.

// File: rtl/sdram_bringup_pkg.sv
package sdram_bringup_pkg;

    typedef enum logic [2:0] {
        OP_NORMAL = 3'b000,
        OP_CBR    = 3'b001,
        OP_MRW    = 3'b011,
        OP_PREA   = 3'b101
    } sdr_op_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PRECH,
        ST_PRE_GAP,
        ST_REFR,
        ST_REF_GAP,
        ST_MRW,
        ST_MRW_GAP,
        ST_NORM,
        ST_RUN
    } seq_state_e;

endpackage

// File: rtl/bringup_gap_timer.sv
module bringup_gap_timer #(
    parameter int GAP_W = 3,
    parameter int MAXV  = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [GAP_W-1:0] load_val,
    output logic             expired
);

    logic [GAP_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expired = (cnt == '0);

    // R3: the wait count never exceeds the longest programmed gap
    p_gap_bound_r3: assert property (@(posedge clk) disable iff (rst)
        (int'(cnt) <= MAXV));

endmodule

// File: rtl/bringup_seq_fsm.sv
module bringup_seq_fsm
    import sdram_bringup_pkg::*;
#(
    parameter int MODE_W = 14,
    parameter int T_RP   = 2,
    parameter int T_RFC  = 7,
    parameter int T_MRD  = 2,
    parameter int N_REFR = 8,
    parameter int GAP_W  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [MODE_W-1:0] mode_word,
    input  logic              gap_zero,
    output logic              gap_load,
    output logic [GAP_W-1:0]  gap_val,
    output logic              cmd_valid,
    output logic [2:0]        cmd_op,
    output logic [MODE_W-1:0] cmd_mode,
    output logic              init_done,
    output logic              en_set
);

    localparam int RC_W = $clog2(N_REFR + 1);

    seq_state_e       state, state_nx;
    logic [RC_W-1:0]  rcnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            rcnt  <= '0;
        end else begin
            state <= state_nx;
            if (state == ST_PRECH) begin
                rcnt <= '0;
            end else if (state == ST_REFR) begin
                rcnt <= rcnt + 1'b1;
            end
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:    if (start) state_nx = ST_PRECH;
            ST_PRECH:   state_nx = ST_PRE_GAP;
            ST_PRE_GAP: if (gap_zero) state_nx = ST_REFR;
            ST_REFR:    state_nx = ST_REF_GAP;
            ST_REF_GAP: if (gap_zero) state_nx = (rcnt == RC_W'(N_REFR)) ? ST_MRW : ST_REFR;
            ST_MRW:     state_nx = ST_MRW_GAP;
            ST_MRW_GAP: if (gap_zero) state_nx = ST_NORM;
            ST_NORM:    state_nx = ST_RUN;
            ST_RUN:     state_nx = ST_RUN;
            default:    state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        cmd_valid = 1'b0;
        cmd_op    = 3'b000;
        cmd_mode  = '0;
        gap_load  = 1'b0;
        gap_val   = '0;
        en_set    = 1'b0;
        init_done = 1'b0;
        unique case (state)
            ST_PRECH: begin
                cmd_valid = 1'b1;
                cmd_op    = OP_PREA;
                gap_load  = 1'b1;
                gap_val   = GAP_W'(T_RP - 1);
            end
            ST_REFR: begin
                cmd_valid = 1'b1;
                cmd_op    = OP_CBR;
                gap_load  = 1'b1;
                gap_val   = GAP_W'(T_RFC - 1);
            end
            ST_MRW: begin
                cmd_valid = 1'b1;
                cmd_op    = OP_MRW;
                cmd_mode  = mode_word;
                gap_load  = 1'b1;
                gap_val   = GAP_W'(T_MRD - 1);
            end
            ST_NORM: begin
                cmd_valid = 1'b1;
                cmd_op    = OP_NORMAL;
                en_set    = 1'b1;
                init_done = 1'b1;
            end
            ST_RUN:  init_done = 1'b1;
            default: ;
        endcase
    end

    p_first_prech_r2: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && start) |=> (cmd_valid && cmd_op == OP_PREA));

    p_strobe_single_r6: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |=> !cmd_valid);

    p_done_sticky_r5: assert property (@(posedge clk) disable iff (rst)
        init_done |=> init_done);

    p_mode_gate_r4: assert property (@(posedge clk) disable iff (rst)
        (cmd_mode != '0) |-> (cmd_valid && cmd_op == OP_MRW));

endmodule

// File: rtl/bringup_refresh_timer.sv
module bringup_refresh_timer #(
    parameter int PRE_W = 16,
    parameter int RT_W  = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en_set,
    input  logic             en_clr,
    input  logic [PRE_W-1:0] presc,
    input  logic [RT_W-1:0]  rtmr,
    output logic             en,
    output logic             req
);

    logic [PRE_W-1:0] pre;
    logic [RT_W-1:0]  cnt;
    logic             pre_wrap;
    logic             expire;

    assign pre_wrap = (pre == presc);
    assign expire   = pre_wrap && (cnt == rtmr);

    always_ff @(posedge clk) begin
        if (rst) begin
            en  <= 1'b0;
            pre <= '0;
            cnt <= '0;
            req <= 1'b0;
        end else begin
            req <= en && expire;
            if (!en) begin
                pre <= '0;
                cnt <= '0;
            end else if (pre_wrap) begin
                pre <= '0;
                cnt <= (cnt == rtmr) ? '0 : cnt + 1'b1;
            end else begin
                pre <= pre + 1'b1;
            end
            if (en_set) begin
                en <= 1'b1;
            end else if (en_clr) begin
                en <= 1'b0;
            end
        end
    end

    p_quiet_when_off_r7: assert property (@(posedge clk) disable iff (rst)
        !en |=> !req);

    p_reload_r8: assert property (@(posedge clk) disable iff (rst)
        !en |=> (pre == '0 && cnt == '0));

endmodule

// File: rtl/sdram_bringup.sv
module sdram_bringup
    import sdram_bringup_pkg::*;
#(
    parameter int MODE_W = 14,
    parameter int T_RP   = 2,
    parameter int T_RFC  = 7,
    parameter int T_MRD  = 2,
    parameter int N_REFR = 8,
    parameter int PRE_W  = 16,
    parameter int RT_W   = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [MODE_W-1:0] mode_word,
    input  logic [PRE_W-1:0]  ref_presc,
    input  logic [RT_W-1:0]   ref_timer,
    input  logic              refresh_clear,
    output logic              cmd_valid,
    output logic [2:0]        cmd_op,
    output logic [MODE_W-1:0] cmd_mode,
    output logic              init_done,
    output logic              refresh_en,
    output logic              refresh_req
);

    localparam int MAX_A = (T_RP > T_RFC) ? T_RP : T_RFC;
    localparam int MAXG  = (MAX_A > T_MRD) ? MAX_A : T_MRD;
    localparam int GAP_W = (MAXG < 2) ? 1 : $clog2(MAXG);

    logic             gap_zero;
    logic             gap_load;
    logic [GAP_W-1:0] gap_val;
    logic             en_set;

    bringup_seq_fsm #(
        .MODE_W (MODE_W),
        .T_RP   (T_RP),
        .T_RFC  (T_RFC),
        .T_MRD  (T_MRD),
        .N_REFR (N_REFR),
        .GAP_W  (GAP_W)
    ) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .mode_word (mode_word),
        .gap_zero  (gap_zero),
        .gap_load  (gap_load),
        .gap_val   (gap_val),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cmd_mode  (cmd_mode),
        .init_done (init_done),
        .en_set    (en_set)
    );

    bringup_gap_timer #(
        .GAP_W (GAP_W),
        .MAXV  (MAXG - 1)
    ) u_gap (
        .clk      (clk),
        .rst      (rst),
        .load     (gap_load),
        .load_val (gap_val),
        .expired  (gap_zero)
    );

    bringup_refresh_timer #(
        .PRE_W (PRE_W),
        .RT_W  (RT_W)
    ) u_rtmr (
        .clk    (clk),
        .rst    (rst),
        .en_set (en_set),
        .en_clr (refresh_clear),
        .presc  (ref_presc),
        .rtmr   (ref_timer),
        .en     (refresh_en),
        .req    (refresh_req)
    );

    // R9: a start after the sequence has completed launches no new precharge
    p_start_ignored_r9: assert property (@(posedge clk) disable iff (rst)
        (init_done && start) |=> !(cmd_valid && cmd_op == OP_PREA));

    // R5: refresh arming follows the normal-operation strobe
    p_arm_after_norm_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(refresh_en) |-> init_done);

endmodule

// File: tb/test_sdram_bringup.sv
`timescale 1ns/1ps
module test_sdram_bringup;

    localparam int MODE_W = 14;
    localparam int T_RP   = 2;
    localparam int T_RFC  = 3;
    localparam int T_MRD  = 1;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start = 1'b0;
    logic [MODE_W-1:0] mode_word = '0;
    logic [15:0]       ref_presc = '0;
    logic [7:0]        ref_timer = '0;
    logic              refresh_clear = 1'b0;
    logic              cmd_valid;
    logic [2:0]        cmd_op;
    logic [MODE_W-1:0] cmd_mode;
    logic              init_done;
    logic              refresh_en;
    logic              refresh_req;

    always #2.5 clk = ~clk;

    sdram_bringup #(
        .MODE_W (MODE_W),
        .T_RP   (T_RP),
        .T_RFC  (T_RFC),
        .T_MRD  (T_MRD)
    ) i_sdram_bringup (
        .clk           (clk),
        .rst           (rst),
        .start         (start),
        .mode_word     (mode_word),
        .ref_presc     (ref_presc),
        .ref_timer     (ref_timer),
        .refresh_clear (refresh_clear),
        .cmd_valid     (cmd_valid),
        .cmd_op        (cmd_op),
        .cmd_mode      (cmd_mode),
        .init_done     (init_done),
        .refresh_en    (refresh_en),
        .refresh_req   (refresh_req)
    );

    int vecs = 0;
    int miscmp = 0;
    int cyc = 0;
    int q[$];
    bit armed = 0;
    bit m_busy = 0;
    bit m_done = 0;
    bit m_ren = 0;
    bit m_req = 0;
    int m_t = 0;
    int per = 1;
    bit set_now;
    int last_req = -1;
    int cbr_cnt = 0;

    task automatic chk(string tag, string what, int act, int exp);
        vecs++;
        if (act != exp) begin
            miscmp++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic tick(int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic pulse_start();
        start = 1'b1;
        tick(1);
        start = 1'b0;
    endtask

    // Behavioural reference model, advanced on every rising edge
    always @(posedge clk) begin
        cyc++;
        armed = 1;
        if (rst) begin
            q.delete();
            m_busy = 0; m_done = 0; m_ren = 0; m_req = 0; m_t = 0;
        end else begin
            per   = (int'(ref_presc) + 1) * (int'(ref_timer) + 1);
            m_req = m_ren && (m_t == per - 1);
            m_t   = m_ren ? ((m_t == per - 1) ? 0 : m_t + 1) : 0;
            set_now = (q.size() > 0) && (q[0] == 0);
            if (q.size() > 0) void'(q.pop_front());
            if (set_now) begin
                m_done = 1;
                m_ren  = 1;
            end else if (refresh_clear) begin
                m_ren = 0;
            end
            if (!m_busy && start) begin
                q.push_back(5);
                for (int i = 0; i < T_RP; i++) q.push_back(-1);
                for (int r = 0; r < 8; r++) begin
                    q.push_back(1);
                    for (int i = 0; i < T_RFC; i++) q.push_back(-1);
                end
                q.push_back(3);
                for (int i = 0; i < T_MRD; i++) q.push_back(-1);
                q.push_back(0);
                m_busy = 1;
            end
        end
    end

    // Compare against the model away from the active edge
    always @(negedge clk) begin
        if (armed) begin
            automatic bit    ev = (q.size() > 0) && (q[0] >= 0);
            automatic int    eop = ev ? q[0] : 0;
            automatic int    emode = (ev && q[0] == 3) ? int'(mode_word) : 0;
            automatic bit    edone = m_done || (ev && q[0] == 0);
            automatic string ct;
            if (q.size() == 0) ct = m_busy ? "R9" : "R1";
            else case (q[0])
                5:       ct = "R2";
                1:       ct = "R3";
                3:       ct = "R4";
                0:       ct = "R5";
                default: ct = "R6";
            endcase
            chk(ct, "cmd_valid", int'(cmd_valid), int'(ev));
            chk(ct, "cmd_op", int'(cmd_op), eop);
            chk((ev && q[0] == 3) ? "R4" : ct, "cmd_mode", int'(cmd_mode), emode);
            chk(m_busy ? "R5" : "R1", "init_done", int'(init_done), int'(edone));
            chk((m_done && !m_ren) ? "R8" : "R5", "refresh_en", int'(refresh_en), int'(m_ren));
            chk(m_ren ? "R7" : "R8", "refresh_req", int'(refresh_req), int'(m_req));
            if (cmd_valid && cmd_op == 3'b001) cbr_cnt++;
            if (!m_ren) last_req = -1;
            if (refresh_req && m_ren) begin
                if (last_req >= 0) chk("R7", "refresh period", cyc - last_req, per);
                last_req = cyc;
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        miscmp++;
        $display("FAIL watchdog (R1..R9 incomplete): actual hung expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", vecs, miscmp);
        $finish;
    end

    initial begin
        tick(3);
        rst = 1'b0;
        tick(2);
        // R1: quiet after reset
        chk("R1", "reset init_done", int'(init_done), 0);
        chk("R1", "reset cmd_valid", int'(cmd_valid), 0);

        // Run 1: period 12, start retried while busy and after done (R9)
        ref_presc = 16'd2; ref_timer = 8'd3; mode_word = 14'h0A5C;
        cbr_cnt = 0;
        pulse_start();
        tick(6);
        pulse_start();
        tick(80);
        chk("R3", "refresh strobes in sequence", cbr_cnt, 8);
        pulse_start();
        tick(10);
        // R8: disarm and observe silence
        refresh_clear = 1'b1;
        tick(1);
        refresh_clear = 1'b0;
        tick(40);
        chk("R8", "refresh_en after clear", int'(refresh_en), 0);

        // Run 2: period 1, reset mid-sequence (R1)
        rst = 1'b1; tick(2); rst = 1'b0;
        ref_presc = 16'd0; ref_timer = 8'd0; mode_word = 14'h3FFF;
        pulse_start();
        tick(12);
        rst = 1'b1; tick(1); rst = 1'b0;
        tick(5);
        chk("R1", "no strobe after mid reset", int'(cmd_valid), 0);
        pulse_start();
        tick(50);
        refresh_clear = 1'b1;
        tick(1);
        refresh_clear = 1'b0;
        tick(10);

        // Run 3: prescaler-only period of 5
        rst = 1'b1; tick(2); rst = 1'b0;
        ref_presc = 16'd4; ref_timer = 8'd0; mode_word = 14'h0001;
        pulse_start();
        tick(70);

        $display("== %0d vectors applied, %0d miscompares ==", vecs, miscmp);
        $finish;
    end

endmodule